// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is an SMBus target that owns a bank of byte-wide configuration registers. It watches the SCL and SDA lines through a two-flop synchroniser, decodes START and STOP conditions, and answers on SDA through an open-drain enable (`sda_oe_o` high pulls the line low). The full register contents are presented in parallel on `regs_o`. `wr_strobe_o` gives a one-cycle pulse for every register that a bus transfer changes.

Three transfers are served. An indexed block write carries an offset, a byte count N and N data bytes. An indexed block read sends an offset, then a repeated START with the read address. The target then returns the stored read-count register, followed by register data from the offset upward. A combined transfer sets the top bit of the count byte in a write. The low seven bits then reload the read-count register, no data bytes follow, and the master turns the transfer into an indexed read with a repeated START.

The protocol state machine has these states:

| State | Role |
|---|---|
| IDLE | Waits for a START. |
| ADDR / ADDR_ACK | Receives and acknowledges the address byte. |
| OFFS / OFFS_ACK | Receives and acknowledges the offset. |
| CNT / CNT_ACK | Receives and acknowledges the count byte. |
| WDATA / WDATA_ACK | Receives, stores and acknowledges data bytes. |
| TX / TX_ACK | Shifts out a byte, then samples the master's acknowledge. |
| HOLD | Waits for a repeated START after a count reload. |
| IGNORE | Keeps SDA released until the next START or STOP. |

The transitions are:
- START from any state goes to ADDR. STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on a match, otherwise to IGNORE.
- ADDR_ACK goes to OFFS for a write, or to TX for a read.
- OFFS goes to OFFS_ACK, then to CNT.
- CNT goes to IGNORE on a zero count, otherwise to CNT_ACK.
- CNT_ACK goes to HOLD when the flag bit is set, otherwise to WDATA.
- WDATA goes to WDATA_ACK while the count lasts, otherwise to IGNORE. WDATA_ACK returns to WDATA.
- TX goes to TX_ACK. TX_ACK returns to TX on an acknowledge, or goes to IGNORE on a not-acknowledge.

Top module: `cfg_smb_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x69, seen on the bus as 0xD2 for write and 0xD3 for read. Any other address byte is not acknowledged, and SDA stays released until the next START or STOP, with no register change.
- R2: In a write, the byte after the address is the offset and the next is the count N (1 to 127, bit 7 clear). N data bytes follow and are stored at consecutive offsets. Every byte is acknowledged.
- R3: A count byte of 0x00 is not acknowledged, and no register changes.
- R4: Data bytes beyond the N announced are not acknowledged and not stored.
- R5: After offset, repeated START and address 0xD3, the target first returns register 8. It then returns registers from the offset upward, for as long as the master acknowledges.
- R6: Register 8 holds the read count in bits 6:0 and resets to 0x0F. Its bit 7 always reads 0. All other writable registers reset to 0x00.
- R7: A count byte with bit 7 set is acknowledged and writes its low seven bits into register 8, and no data bytes are taken. A following repeated-START read returns that new count first.
- R8: The offset increments after every stored or transmitted data byte and wraps from NUM_REGS-1 to 0. An offset of NUM_REGS or more starts at 0.
- R9: Register 7 is read-only and always reads ID_VAL (0x15). Writes to it are acknowledged, leave it unchanged and give no strobe.
- R10: Each accepted write to register i, including a count reload of register 8, gives exactly one single-cycle pulse on `wr_strobe_o[i]`. At most one strobe bit is high in any cycle.
- R11: A START or STOP in the middle of a transfer abandons it. Bytes already completed stay stored, and a partial byte is discarded.
- R12: `sda_oe_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired value) |
| sda_oe_o | output | 1 | High pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register contents, register i at bits 8i+7:8i |
| wr_strobe_o | output | NUM_REGS | One-cycle pulse per register written |

## Verification
Internal state surfaces at the ports within one byte, at most nine SCL periods. A wrong bit counter or state moves the acknowledge slot, which the master sees as a lost or stray ACK. A wrong offset pointer or count register shows up as the wrong byte in the next read and on `regs_o`. A missed or extra strobe shows up as a per-register pulse count that differs from what the transfers imply. A transition taken while SCL is high would look like a false START or STOP on the bus, so SDA activity is also checked against SCL on every clock.

// File: rtl/cfg_smb_pkg.sv
package cfg_smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD,
        ST_IGNORE
    } smb_state_e;

endpackage

// File: rtl/cfg_smb_sync.sv
module cfg_smb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;
    logic       sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    assign scl_s     = scl_ff[1];
    assign sda_s     = sda_ff[1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SDA edges while SCL stays high on both samples
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_smb_regbank.sv
module cfg_smb_regbank #(
    parameter int         NUM_REGS = 36,
    parameter int         BC_IDX   = 8,
    parameter logic [7:0] BC_RESET = 8'h0F,
    parameter int         ID_IDX   = 7,
    parameter logic [7:0] ID_VAL   = 8'h15,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [PTR_W-1:0]      wr_idx_i,
    input  logic [7:0]            wr_data_i,
    input  logic                  bc_wr_i,
    input  logic [6:0]            bc_data_i,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   wr_strobe_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == ID_IDX) begin : g_ro
            assign regs_o[g*8 +: 8] = ID_VAL;
            assign wr_strobe_o[g]   = 1'b0;
        end else begin : g_rw
            logic [7:0] val_q;
            logic       stb_q;
            logic       hit;
            logic       bc_hit;

            assign hit    = wr_en_i && (wr_idx_i == PTR_W'(g));
            assign bc_hit = (g == BC_IDX) && bc_wr_i;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= (g == BC_IDX) ? {1'b0, BC_RESET[6:0]} : 8'h00;
                    stb_q <= 1'b0;
                end else begin
                    stb_q <= hit || bc_hit;
                    if (hit) begin
                        val_q <= (g == BC_IDX) ? {1'b0, wr_data_i[6:0]} : wr_data_i;
                    end else if (bc_hit) begin
                        val_q <= {1'b0, bc_data_i};
                    end
                end
            end

            assign regs_o[g*8 +: 8] = val_q;
            assign wr_strobe_o[g]   = stb_q;
        end
    end

    // R10: never more than one strobe at a time
    p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe_o));

    // R2: a write request to a writable register is followed by its strobe
    p_write_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (int'(wr_idx_i) != ID_IDX)) |=> wr_strobe_o[$past(wr_idx_i)]);

    // R7: a count reload lands in the count register on the next cycle
    p_count_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bc_wr_i |=> (regs_o[BC_IDX*8 +: 8] == {1'b0, $past(bc_data_i)}));

endmodule

// File: rtl/cfg_smb_target.sv
module cfg_smb_target
    import cfg_smb_pkg::*;
#(
    parameter int         NUM_REGS = 36,
    parameter logic [6:0] TGT_ADDR = 7'h69,
    parameter int         BC_IDX   = 8,
    parameter logic [7:0] BC_RESET = 8'h0F,
    parameter int         ID_IDX   = 7,
    parameter logic [7:0] ID_VAL   = 8'h15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   wr_strobe_o
);
    localparam int PTR_W = $clog2(NUM_REGS);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smb_state_e state_q, state_d;

    logic [3:0]          bit_cnt_q;
    logic [7:0]          sh_q;
    logic [7:0]          tx_sh_q;
    logic                rw_q;
    logic                cnt_load_q;
    logic                mack_q;
    logic [6:0]          left_q;
    logic [PTR_W-1:0]    ptr_q;
    logic                wr_en_q;
    logic [PTR_W-1:0]    wr_idx_q;
    logic [7:0]          wr_data_q;
    logic                bc_wr_q;
    logic [6:0]          bc_data_q;
    logic                byte_done;
    logic                counting;
    logic                addr_hit;
    logic [NUM_REGS*8-1:0] regs_w;
    logic [7:0]          rd_byte;
    logic [7:0]          bc_byte;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    cfg_smb_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_smb_regbank #(
        .NUM_REGS (NUM_REGS),
        .BC_IDX   (BC_IDX),
        .BC_RESET (BC_RESET),
        .ID_IDX   (ID_IDX),
        .ID_VAL   (ID_VAL)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_q),
        .wr_idx_i    (wr_idx_q),
        .wr_data_i   (wr_data_q),
        .bc_wr_i     (bc_wr_q),
        .bc_data_i   (bc_data_q),
        .regs_o      (regs_w),
        .wr_strobe_o (wr_strobe_o)
    );

    assign regs_o    = regs_w;
    assign rd_byte   = regs_w[int'(ptr_q)*8 +: 8];
    assign bc_byte   = regs_w[BC_IDX*8 +: 8];
    assign byte_done = (bit_cnt_q == 4'd8);
    assign addr_hit  = (sh_q[7:1] == TGT_ADDR);
    assign counting  = (state_q == ST_ADDR) || (state_q == ST_OFFS) ||
                       (state_q == ST_CNT)  || (state_q == ST_WDATA) ||
                       (state_q == ST_TX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: bus conditions first, then byte boundaries on SCL falls
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE, ST_HOLD, ST_IGNORE: state_d = state_q;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  state_d = rw_q ? ST_TX : ST_OFFS;
                ST_OFFS:      if (byte_done) state_d = ST_OFFS_ACK;
                ST_OFFS_ACK:  state_d = ST_CNT;
                ST_CNT:       if (byte_done) state_d = (sh_q == 8'h00) ? ST_IGNORE : ST_CNT_ACK;
                ST_CNT_ACK:   state_d = cnt_load_q ? ST_HOLD : ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = (left_q == 7'd0) ? ST_IGNORE : ST_WDATA_ACK;
                ST_WDATA_ACK: state_d = ST_WDATA;
                ST_TX:        if (byte_done) state_d = ST_TX_ACK;
                ST_TX_ACK:    state_d = mack_q ? ST_TX : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: shift registers, pointer, counters, register requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            sh_q       <= '0;
            tx_sh_q    <= '1;
            rw_q       <= 1'b0;
            cnt_load_q <= 1'b0;
            mack_q     <= 1'b0;
            left_q     <= '0;
            ptr_q      <= '0;
            wr_en_q    <= 1'b0;
            wr_idx_q   <= '0;
            wr_data_q  <= '0;
            bc_wr_q    <= 1'b0;
            bc_data_q  <= '0;
        end else begin
            wr_en_q <= 1'b0;
            bc_wr_q <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt_q <= '0;
            end else if (scl_rise) begin
                if (counting) begin
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                    sh_q      <= {sh_q[6:0], sda_s};
                end
                if (state_q == ST_TX_ACK) begin
                    mack_q <= ~sda_s;
                end
            end else if (scl_fall) begin
                if (byte_done) begin
                    bit_cnt_q <= '0;
                end
                case (state_q)
                    ST_ADDR: begin
                        if (byte_done) rw_q <= sh_q[0];
                    end
                    ST_ADDR_ACK: begin
                        if (rw_q) tx_sh_q <= bc_byte;
                    end
                    ST_OFFS: begin
                        if (byte_done) begin
                            ptr_q <= (int'(sh_q) < NUM_REGS) ? sh_q[PTR_W-1:0] : '0;
                        end
                    end
                    ST_CNT: begin
                        if (byte_done) begin
                            cnt_load_q <= sh_q[7];
                            left_q     <= sh_q[6:0];
                            if (sh_q[7]) begin
                                bc_wr_q   <= 1'b1;
                                bc_data_q <= sh_q[6:0];
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (byte_done && (left_q != 7'd0)) begin
                            wr_en_q   <= (int'(ptr_q) != ID_IDX);
                            wr_idx_q  <= ptr_q;
                            wr_data_q <= sh_q;
                            ptr_q     <= ptr_inc(ptr_q);
                            left_q    <= left_q - 7'd1;
                        end
                    end
                    ST_TX: begin
                        if (!byte_done) tx_sh_q <= {tx_sh_q[6:0], 1'b1};
                    end
                    ST_TX_ACK: begin
                        if (mack_q) begin
                            tx_sh_q <= rd_byte;
                            ptr_q   <= ptr_inc(ptr_q);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_OFFS_ACK, ST_CNT_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_TX:   sda_oe_o = ~tx_sh_q[7];
            default: sda_oe_o = 1'b0;
        endcase
    end

    // R12: the target only moves SDA while SCL is low
    p_sda_moves_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

    // R8: the offset pointer never leaves the register space
    p_ptr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < NUM_REGS);

endmodule

// File: tb/cfg_smb_target_tb_top.sv
module cfg_smb_target_tb_top;
    localparam int         NUM_REGS = 36;
    localparam int         ID_IDX   = 7;
    localparam logic [7:0] ID_VAL   = 8'h15;
    localparam int         BC_IDX   = 8;
    localparam int         Q        = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NUM_REGS*8-1:0] regs;
    logic [NUM_REGS-1:0]   stb;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    cfg_smb_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .regs_o      (regs),
        .wr_strobe_o (stb)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_r [NUM_REGS];
    int exp_stb [NUM_REGS];
    int got_stb [NUM_REGS];
    int multi_stb = 0;
    int r12_viol = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    logic [7:0] buf_b [0:7];
    logic [7:0] rd_b [0:8];
    logic ack_a, ack_o, ack_c, ack_r;
    logic ack_d [0:7];

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        int bad = 0;
        checks++;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (regs[i*8 +: 8] !== exp_r[i]) begin
                bad++;
                $display("FAIL %s reg%0d actual=%0h expected=%0h", req, i, regs[i*8 +: 8], exp_r[i]);
            end
        end
        if (bad != 0) errors++;
    endtask

    // monitor, sampled mid-cycle away from both clock edges
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (scl_prev && scl_m && (sda_oe !== oe_prev)) r12_viol++;
            if ($countones(stb) > 1) multi_stb++;
            for (int i = 0; i < NUM_REGS; i++) if (stb[i]) got_stb[i]++;
        end
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = !sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        wq(); sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq(); sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] off, input logic [7:0] cnt, input int nsend);
        bus_start();
        send_byte(8'hD2, ack_a);
        send_byte(off, ack_o);
        send_byte(cnt, ack_c);
        for (int i = 0; i < nsend; i++) send_byte(buf_b[i], ack_d[i]);
        bus_stop();
        wq();
    endtask

    task automatic rd_txn(input logic [7:0] off, input int n);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(off, a);
        bus_start();
        send_byte(8'hD3, ack_r);
        recv_byte(rd_b[0], 1'b1);
        for (int i = 0; i < n; i++) recv_byte(rd_b[i+1], i != n - 1);
        bus_stop();
        wq();
    endtask

    function automatic int wrap_inc(input int p);
        return (p == NUM_REGS - 1) ? 0 : p + 1;
    endfunction

    task automatic model_write(input int off, input int n);
        int p = (off >= NUM_REGS) ? 0 : off;
        for (int i = 0; i < n; i++) begin
            if (p != ID_IDX) begin
                exp_r[p] = (p == BC_IDX) ? {1'b0, buf_b[i][6:0]} : buf_b[i];
                exp_stb[p]++;
            end
            p = wrap_inc(p);
        end
    endtask

    task automatic check_read(input string req, input int off, input int n);
        int p = off;
        rd_txn(8'(off), n);
        chk(req, "read addr ack", int'(ack_r), 1);
        chk(req, "count byte", int'(rd_b[0]), int'(exp_r[BC_IDX]));
        for (int i = 0; i < n; i++) begin
            chk(req, "read data", int'(rd_b[i+1]), int'(exp_r[p]));
            p = wrap_inc(p);
        end
    endtask

    initial begin
        logic a;
        int sbad;
        for (int i = 0; i < NUM_REGS; i++) begin
            exp_r[i] = 8'h00; exp_stb[i] = 0; got_stb[i] = 0;
        end
        exp_r[BC_IDX] = 8'h0F;
        exp_r[ID_IDX] = ID_VAL;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state: R6 count register default, R9 identity value
        check_regs("R6 R9 reset");
        chk("R12", "sda_oe after reset", int'(sda_oe), 0);

        // R1: foreign address, write and read forms
        bus_start(); send_byte(8'hA4, a); send_byte(8'h03, ack_o); bus_stop(); wq();
        chk("R1", "foreign addr ack", int'(a), 0);
        check_regs("R1");
        bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a);
        bus_start(); send_byte(8'hD5, a); bus_stop(); wq();
        chk("R1", "foreign read addr ack", int'(a), 0);

        // R2: block write of three bytes at offset 2
        buf_b[0] = 8'h11; buf_b[1] = 8'h22; buf_b[2] = 8'h33;
        wr_txn(8'd2, 8'd3, 3);
        chk("R2", "all acks", int'(ack_a & ack_o & ack_c & ack_d[0] & ack_d[1] & ack_d[2]), 1);
        model_write(2, 3);
        check_regs("R2");

        // R5: indexed read returns count then data
        check_read("R5", 2, 3);

        // R3: zero count rejected
        buf_b[0] = 8'hEE;
        wr_txn(8'd4, 8'd0, 1);
        chk("R3", "zero count ack", int'(ack_c), 0);
        check_regs("R3");

        // R4: surplus byte refused
        buf_b[0] = 8'h44; buf_b[1] = 8'h55; buf_b[2] = 8'h66;
        wr_txn(8'd5, 8'd2, 3);
        chk("R4", "in-count acks", int'(ack_d[0] & ack_d[1]), 1);
        chk("R4", "surplus ack", int'(ack_d[2]), 0);
        model_write(5, 2);
        check_regs("R4");

        // R8: wrap at the end of the register space
        buf_b[0] = 8'hA0; buf_b[1] = 8'hA1; buf_b[2] = 8'hA2; buf_b[3] = 8'hA3;
        wr_txn(8'(NUM_REGS - 2), 8'd4, 4);
        model_write(NUM_REGS - 2, 4);
        check_regs("R8 wrap write");
        check_read("R8", NUM_REGS - 2, 4);

        // R8: offset beyond the space starts at 0
        buf_b[0] = 8'h5A;
        wr_txn(8'd200, 8'd1, 1);
        model_write(200, 1);
        check_regs("R8 out of range");

        // R9: read-only identity register
        buf_b[0] = 8'hEE; buf_b[1] = 8'h77;
        wr_txn(8'd7, 8'd2, 2);
        chk("R9", "ro write acks", int'(ack_d[0] & ack_d[1]), 1);
        model_write(7, 2);
        check_regs("R9");
        chk("R9", "ro strobes", got_stb[ID_IDX], 0);

        // R6: bit 7 of the count register reads 0
        buf_b[0] = 8'hFF;
        wr_txn(8'd8, 8'd1, 1);
        model_write(8, 1);
        check_regs("R6 msb");
        check_read("R6", 8, 1);

        // R7: combined count reload and read
        bus_start();
        send_byte(8'hD2, a); send_byte(8'd20, a); send_byte(8'h83, ack_c);
        bus_start();
        send_byte(8'hD3, ack_r);
        recv_byte(rd_b[0], 1'b1);
        recv_byte(rd_b[1], 1'b1);
        recv_byte(rd_b[2], 1'b1);
        recv_byte(rd_b[3], 1'b0);
        bus_stop(); wq();
        exp_r[BC_IDX] = 8'h03; exp_stb[BC_IDX]++;
        chk("R7", "flag count ack", int'(ack_c), 1);
        chk("R7", "read addr ack", int'(ack_r), 1);
        chk("R7", "new count first", int'(rd_b[0]), 8'h03);
        chk("R7", "data 20", int'(rd_b[1]), int'(exp_r[20]));
        chk("R7", "data 22", int'(rd_b[3]), int'(exp_r[22]));
        check_regs("R7");

        // R11: STOP mid-byte keeps the finished byte only
        bus_start();
        send_byte(8'hD2, a); send_byte(8'd10, a); send_byte(8'd3, a);
        send_byte(8'hC1, a);
        send_bits(8'hC2, 4);
        bus_stop(); wq();
        exp_r[10] = 8'hC1; exp_stb[10]++;
        check_regs("R11 stop");

        // R11: START mid-byte, then a fresh write
        bus_start();
        send_byte(8'hD2, a); send_byte(8'd12, a); send_byte(8'd2, a);
        send_bits(8'h99, 3);
        bus_start();
        send_byte(8'hD2, a); send_byte(8'd13, a); send_byte(8'd1, a);
        send_byte(8'h6D, a);
        bus_stop(); wq();
        exp_r[13] = 8'h6D; exp_stb[13]++;
        check_regs("R11 start");

        // R10: strobe counts per register
        repeat (5) @(negedge clk);
        sbad = 0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (got_stb[i] != exp_stb[i]) begin
                sbad++;
                $display("FAIL R10 strobes reg%0d actual=%0d expected=%0d", i, got_stb[i], exp_stb[i]);
            end
        end
        checks++;
        if (sbad != 0) errors++;
        chk("R10", "overlapping strobes", multi_stb, 0);

        // R12: SDA never moved while SCL was high
        chk("R12", "sda moves with scl high", r12_viol, 0);

        report();
        $finish;
    end

endmodule